// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for one display output channel, plus a 24-bit pixel word for a built-in colour-bar pattern. Every timing value comes from a register input: the widths of both sync pulses, both back porches, both front porches, the active pixels per line and the active lines per frame. Each of the three strobes has its own polarity-invert input.

The block works in one of two modes. With the pattern enable low it re-times an upstream source. A rising edge on the incoming horizontal or vertical sync is held back by a programmable number of pixel clocks, then launches one output line or an output vertical pulse. With the pattern enable high it ignores the incoming syncs and free-runs whole frames from its own counters, filling the active area with vertical colour bars.

Top module: `vtg_top`

## Requirements
- R1: During and right after reset every strobe sits at its inactive level (data-enable equals its invert bit, each sync equals its invert bit) and the pixel word is zero.
- R2: Each strobe is its internal active-high value XOR its own invert bit: data-enable is active-high when its bit is 0, and each sync is active-low when its bit is 1.
- R3: In pattern mode a line is, in order, sync (hs_width_i clocks), back porch (h_back_i), active (act_pix_i, data-enable on) and front porch (h_front_i). The next line follows with no gap, so the line period is the sum of the four.
- R4: In pattern mode a frame is, in order, vertical sync (vs_width_i lines), back porch (v_back_i lines), active (act_lines_i lines, the only lines with data-enable) and front porch (v_front_i lines). Frames repeat with no gap. The first frame's first line starts two clocks after pattern_en_i is sampled high.
- R5: A length of zero in any sync, porch or active field skips that phase and adds no clock or line.
- R6: In pattern mode, during an enabled pixel at active index x (0 = first), bar b = (x >> 4) mod 8 gives R = 0xFF if b[2] is set, G = 0xFF if b[1] is set and B = 0xFF if b[0] is set, with R in rgb_o[23:16], G in [15:8] and B in [7:0]. Outside data-enable, or when not in pattern mode, rgb_o is zero.
- R7: In re-time mode, a rising edge of hs_in_i sampled at clock edge k makes horizontal sync go active after edge k+D, where D is the effective delay. That starts one line in R3's order, after which the strobes stay idle until the next launch.
- R8: The effective delay D is sync_dly_i, or 32 whenever sync_dly_i is below 32.
- R9: In re-time mode, a rising edge of vs_in_i makes vertical sync go active after the same delay D. It stays active until vs_width_i output lines have ended, and data-enable stays off for those lines.
- R10: Any change of pattern_en_i returns both counters to idle and discards pending delayed events, so a sync received before a pattern run never appears after it.
- R11: A new rising edge on an incoming sync while its delay is still counting restarts the delay from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_pix_i | input | 12 | Active pixels per line |
| act_lines_i | input | 12 | Active lines per frame (pattern mode) |
| hs_width_i | input | 10 | Horizontal sync width in clocks |
| vs_width_i | input | 10 | Vertical sync width in lines |
| h_back_i | input | 8 | Horizontal back porch in clocks |
| h_front_i | input | 8 | Horizontal front porch in clocks |
| v_back_i | input | 8 | Vertical back porch in lines (pattern mode) |
| v_front_i | input | 8 | Vertical front porch in lines (pattern mode) |
| sync_dly_i | input | 12 | Incoming-sync delay in clocks, minimum 32 |
| de_inv_i | input | 1 | Invert data-enable |
| hs_inv_i | input | 1 | Invert horizontal sync |
| vs_inv_i | input | 1 | Invert vertical sync |
| pattern_en_i | input | 1 | Free-run colour-bar mode |
| hs_in_i | input | 1 | Incoming horizontal sync, active-high |
| vs_in_i | input | 1 | Incoming vertical sync, active-high |
| de_o | output | 1 | Data-enable strobe |
| hs_o | output | 1 | Horizontal sync strobe |
| vs_o | output | 1 | Vertical sync strobe |
| rgb_o | output | 24 | Pattern pixel, zero outside pattern data-enable |

## Verification
The properties assume that the timing and polarity inputs stay constant while the counters run, and that incoming syncs arrive only in re-time mode. The stimulus follows this: it changes configuration only while the pattern enable is low and the strobes are idle, and it sends sync pulses only with the pattern enable held low. The minimum-delay property also assumes that a horizontal launch comes only from an incoming edge. The stimulus therefore never toggles the pattern enable within one clock of a sync pulse, except in the one test that checks that a pending event is discarded.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [2:0] {
        PH_SYNC  = 3'd0,
        PH_BACK  = 3'd1,
        PH_ACT   = 3'd2,
        PH_FRONT = 3'd3,
        PH_IDLE  = 3'd4
    } phase_e;

    // First phase at or after 'from' whose length is nonzero; PH_IDLE if none.
    function automatic phase_e seek_phase(input logic [3:0] nz, input logic [2:0] from);
        phase_e r;
        r = PH_IDLE;
        for (int i = 3; i >= 0; i--) begin
            if (nz[i] && (3'(i) >= from)) r = phase_e'(3'(i));
        end
        return r;
    endfunction

    function automatic logic [1:0] ph_idx(input phase_e p);
        return p[1:0];
    endfunction

endpackage

// File: rtl/vtg_sync_delay.sv
module vtg_sync_delay #(
    parameter int DLY_W   = 12,
    parameter int MIN_DLY = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ev_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             fire_o
);

    typedef struct packed {
        logic             prev;
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic [DLY_W-1:0] eff_dly;

    assign eff_dly = (dly_i < DLY_W'(MIN_DLY)) ? DLY_W'(MIN_DLY) : dly_i;
    assign fire_o  = st_q.pend && (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.prev = ev_i;
        if (fire_o) begin
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (ev_i && !st_q.prev) begin
            st_d.pend = 1'b1;
            st_d.cnt  = eff_dly - 1'b1;
        end
        if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
    import vtg_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0][PIX_W-1:0] hlen_i,
    input  logic [3:0][PIX_W-1:0] vlen_i,
    input  logic                  tp_en_i,
    input  logic                  hs_fire_i,
    input  logic                  vs_fire_i,
    output logic                  mode_chg_o,
    output logic                  tp_run_o,
    output logic                  hs_raw_o,
    output logic                  vs_raw_o,
    output logic                  de_raw_o,
    output logic [PIX_W-1:0]      x_o
);

    typedef struct packed {
        phase_e           hph;
        phase_e           vph;
        logic [PIX_W-1:0] hcnt;
        logic [PIX_W-1:0] vcnt;
        logic             tp;
    } rst_st_t;

    rst_st_t st_d, st_q;
    logic [3:0] hnz, vnz;
    logic       line_end;
    phase_e     nh, nv, sh, sv;

    for (genvar g = 0; g < 4; g++) begin : g_nz
        assign hnz[g] = (hlen_i[g] != '0);
        assign vnz[g] = (vlen_i[g] != '0);
    end

    assign mode_chg_o = (tp_en_i != st_q.tp);
    assign sh         = seek_phase(hnz, 3'd0);
    assign sv         = seek_phase(vnz, 3'd0);

    always_comb begin
        st_d     = st_q;
        st_d.tp  = tp_en_i;
        line_end = 1'b0;
        nh       = PH_IDLE;
        nv       = PH_IDLE;
        if (mode_chg_o) begin
            st_d.hph  = PH_IDLE;
            st_d.vph  = PH_IDLE;
            st_d.hcnt = '0;
            st_d.vcnt = '0;
        end else begin
            // horizontal phase stepping
            if (st_q.hph != PH_IDLE) begin
                if (st_q.hcnt == '0) begin
                    nh       = seek_phase(hnz, 3'(st_q.hph) + 3'd1);
                    st_d.hph = nh;
                    if (nh == PH_IDLE) line_end = 1'b1;
                    else               st_d.hcnt = hlen_i[ph_idx(nh)] - 1'b1;
                end else begin
                    st_d.hcnt = st_q.hcnt - 1'b1;
                end
            end
            // vertical stepping at each line end
            if (line_end) begin
                if (st_q.tp) begin
                    if (st_q.vph != PH_IDLE) begin
                        if (st_q.vcnt == '0) begin
                            nv = seek_phase(vnz, 3'(st_q.vph) + 3'd1);
                            if (nv == PH_IDLE) nv = sv;
                            st_d.vph = nv;
                            if (nv != PH_IDLE) st_d.vcnt = vlen_i[ph_idx(nv)] - 1'b1;
                        end else begin
                            st_d.vcnt = st_q.vcnt - 1'b1;
                        end
                    end
                end else if (st_q.vph == PH_SYNC) begin
                    if (st_q.vcnt == '0) st_d.vph  = PH_ACT;
                    else                 st_d.vcnt = st_q.vcnt - 1'b1;
                end
            end
            // line and frame launches
            if (st_q.tp) begin
                if (line_end || (st_q.hph == PH_IDLE)) begin
                    st_d.hph = sh;
                    if (sh != PH_IDLE) st_d.hcnt = hlen_i[ph_idx(sh)] - 1'b1;
                end
                if (st_q.vph == PH_IDLE) begin
                    st_d.vph = sv;
                    if (sv != PH_IDLE) st_d.vcnt = vlen_i[ph_idx(sv)] - 1'b1;
                end
            end else begin
                if (hs_fire_i) begin
                    st_d.hph = sh;
                    if (sh != PH_IDLE) st_d.hcnt = hlen_i[ph_idx(sh)] - 1'b1;
                end
                if (vs_fire_i && vnz[0]) begin
                    st_d.vph  = PH_SYNC;
                    st_d.vcnt = vlen_i[0] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hph  <= PH_IDLE;
            st_q.vph  <= PH_IDLE;
            st_q.hcnt <= '0;
            st_q.vcnt <= '0;
            st_q.tp   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tp_run_o = st_q.tp;
    assign hs_raw_o = (st_q.hph == PH_SYNC);
    assign vs_raw_o = (st_q.vph == PH_SYNC);
    assign de_raw_o = (st_q.hph == PH_ACT) &&
                      (st_q.tp ? (st_q.vph == PH_ACT) : (st_q.vph != PH_SYNC));
    assign x_o      = hlen_i[2] - 1'b1 - st_q.hcnt;

endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern #(
    parameter int PIX_W     = 12,
    parameter int BAR_SHIFT = 4
) (
    input  logic             en_i,
    input  logic [PIX_W-1:0] x_i,
    output logic [23:0]      rgb_o
);

    logic [2:0] bar;

    assign bar   = x_i[BAR_SHIFT+2:BAR_SHIFT];
    assign rgb_o = en_i ? {{8{bar[2]}}, {8{bar[1]}}, {8{bar[0]}}} : 24'h0;

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
    parameter int PIX_W     = 12,
    parameter int SYNC_W    = 10,
    parameter int PORCH_W   = 8,
    parameter int DLY_W     = 12,
    parameter int MIN_DLY   = 32,
    parameter int BAR_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   act_pix_i,
    input  logic [PIX_W-1:0]   act_lines_i,
    input  logic [SYNC_W-1:0]  hs_width_i,
    input  logic [SYNC_W-1:0]  vs_width_i,
    input  logic [PORCH_W-1:0] h_back_i,
    input  logic [PORCH_W-1:0] h_front_i,
    input  logic [PORCH_W-1:0] v_back_i,
    input  logic [PORCH_W-1:0] v_front_i,
    input  logic [DLY_W-1:0]   sync_dly_i,
    input  logic               de_inv_i,
    input  logic               hs_inv_i,
    input  logic               vs_inv_i,
    input  logic               pattern_en_i,
    input  logic               hs_in_i,
    input  logic               vs_in_i,
    output logic               de_o,
    output logic               hs_o,
    output logic               vs_o,
    output logic [23:0]        rgb_o
);

    localparam int N_EV = 2;

    logic [3:0][PIX_W-1:0] hlen, vlen;
    logic [N_EV-1:0]       ev_in, ev_fire;
    logic                  mode_chg, tp_run, hs_raw, vs_raw, de_raw;
    logic [PIX_W-1:0]      x_pos;

    assign hlen  = {PIX_W'(h_front_i), act_pix_i,   PIX_W'(h_back_i), PIX_W'(hs_width_i)};
    assign vlen  = {PIX_W'(v_front_i), act_lines_i, PIX_W'(v_back_i), PIX_W'(vs_width_i)};
    assign ev_in = {vs_in_i, hs_in_i};

    for (genvar g = 0; g < N_EV; g++) begin : g_dly
        vtg_sync_delay #(.DLY_W(DLY_W), .MIN_DLY(MIN_DLY)) dly_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (mode_chg),
            .ev_i   (ev_in[g]),
            .dly_i  (sync_dly_i),
            .fire_o (ev_fire[g])
        );
    end

    vtg_raster #(.PIX_W(PIX_W)) raster_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hlen_i     (hlen),
        .vlen_i     (vlen),
        .tp_en_i    (pattern_en_i),
        .hs_fire_i  (ev_fire[0]),
        .vs_fire_i  (ev_fire[1]),
        .mode_chg_o (mode_chg),
        .tp_run_o   (tp_run),
        .hs_raw_o   (hs_raw),
        .vs_raw_o   (vs_raw),
        .de_raw_o   (de_raw),
        .x_o        (x_pos)
    );

    vtg_pattern #(.PIX_W(PIX_W), .BAR_SHIFT(BAR_SHIFT)) pattern_i (
        .en_i  (de_raw && tp_run),
        .x_i   (x_pos),
        .rgb_o (rgb_o)
    );

    assign de_o = de_raw ^ de_inv_i;
    assign hs_o = hs_raw ^ hs_inv_i;
    assign vs_o = vs_raw ^ vs_inv_i;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int MIN_DLY = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pattern_en_i,
    input logic        hs_in_i,
    input logic        de_inv_i,
    input logic        hs_inv_i,
    input logic        vs_inv_i,
    input logic        de_o,
    input logic        hs_o,
    input logic        vs_o,
    input logic [23:0] rgb_o
);

    localparam int CW = $clog2(MIN_DLY + 1) + 1;

    logic          de_act, hs_act, vs_act;
    logic          in_prev_q;
    logic [CW-1:0] since_q;

    assign de_act = de_o ^ de_inv_i;
    assign hs_act = hs_o ^ hs_inv_i;
    assign vs_act = vs_o ^ vs_inv_i;

    // clocks elapsed since the latest incoming horizontal edge, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_prev_q <= 1'b0;
            since_q   <= '0;
        end else begin
            in_prev_q <= hs_in_i;
            if (hs_in_i && !in_prev_q)         since_q <= '0;
            else if (since_q < CW'(MIN_DLY))   since_q <= since_q + 1'b1;
        end
    end

    a_r3_sync_not_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_act && de_act));

    a_r9_no_de_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        vs_act |-> !de_act);

    a_r6_rgb_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !de_act |-> (rgb_o == 24'h0));

    a_r6_rgb_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ((rgb_o[23:16] == 8'h00) || (rgb_o[23:16] == 8'hFF)) &&
        ((rgb_o[15:8]  == 8'h00) || (rgb_o[15:8]  == 8'hFF)) &&
        ((rgb_o[7:0]   == 8'h00) || (rgb_o[7:0]   == 8'hFF)));

    a_r8_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_en_i && !$past(pattern_en_i) && $stable(hs_inv_i) && $rose(hs_act))
        |-> (since_q >= CW'(MIN_DLY)));

endmodule

bind vtg_top vtg_checker #(.MIN_DLY(MIN_DLY)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pattern_en_i (pattern_en_i),
    .hs_in_i      (hs_in_i),
    .de_inv_i     (de_inv_i),
    .hs_inv_i     (hs_inv_i),
    .vs_inv_i     (vs_inv_i),
    .de_o         (de_o),
    .hs_o         (hs_o),
    .vs_o         (vs_o),
    .rgb_o        (rgb_o)
);

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb_top;

    localparam int ROWS = 5;
    localparam int NF   = 11;
    // hsw, hbp, act, hfp, vsw, vbp, vact, vfp, de_inv, hs_inv, vs_inv
    localparam int VEC [ROWS][NF] = '{
        '{3, 2,  40, 4, 2, 1, 4, 1, 0, 1, 1},
        '{0, 0,  20, 2, 1, 0, 3, 0, 1, 0, 0},
        '{5, 3,  36, 0, 0, 2, 3, 2, 0, 0, 0},
        '{1, 0,   1, 0, 1, 0, 1, 0, 1, 1, 1},
        '{2, 1, 130, 1, 1, 0, 2, 0, 0, 1, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] act_pix = '0, act_lines = '0, sync_dly = '0;
    logic [9:0]  hs_width = '0, vs_width = '0;
    logic [7:0]  h_back = '0, h_front = '0, v_back = '0, v_front = '0;
    logic        de_inv = 1'b0, hs_inv = 1'b1, vs_inv = 1'b1;
    logic        pattern_en = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic        de_o, hs_o, vs_o;
    logic [23:0] rgb_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vtg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .act_pix_i(act_pix), .act_lines_i(act_lines),
        .hs_width_i(hs_width), .vs_width_i(vs_width),
        .h_back_i(h_back), .h_front_i(h_front),
        .v_back_i(v_back), .v_front_i(v_front),
        .sync_dly_i(sync_dly),
        .de_inv_i(de_inv), .hs_inv_i(hs_inv), .vs_inv_i(vs_inv),
        .pattern_en_i(pattern_en), .hs_in_i(hs_in), .vs_in_i(vs_in),
        .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .rgb_o(rgb_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic set_line(input int hsw, input int hbp, input int act, input int hfp);
        hs_width = 10'(hsw); h_back = 8'(hbp); act_pix = 12'(act); h_front = 8'(hfp);
    endtask

    // count posedges from an input edge until a strobe becomes active
    task automatic launch(input bit vert, input int limit, output int n);
        n = 0;
        if (vert) vs_in = 1'b1; else hs_in = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 1) begin hs_in = 1'b0; vs_in = 1'b0; end
            if (vert ? (vs_o != vs_inv) : (hs_o != hs_inv)) break;
        end
    endtask

    // count active strobes over a window starting at the current negedge
    task automatic window(input int len, output int nhs, output int nde);
        nhs = 0; nde = 0;
        for (int i = 0; i < len; i++) begin
            if (hs_o != hs_inv) nhs++;
            if (de_o != de_inv) nde++;
            @(negedge clk);
        end
    endtask

    task automatic retime_cfg(input int dly);
        set_line(3, 2, 5, 1);
        vs_width = 10'd2; act_lines = 12'd2; v_back = 8'd0; v_front = 8'd0;
        de_inv = 1'b0; hs_inv = 1'b1; vs_inv = 1'b1;
        sync_dly = 12'(dly);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R3 watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int n, nhs, nde;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(de_o == 1'b0 && hs_o == 1'b1 && vs_o == 1'b1, "R1 strobes in reset",
            {de_o, hs_o, vs_o}, 3'b011);
        chk(rgb_o == 24'h0, "R1 rgb in reset", rgb_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(de_o == 1'b0 && hs_o == 1'b1 && vs_o == 1'b1, "R1 strobes after reset",
            {de_o, hs_o, vs_o}, 3'b011);

        // R2 R3 R4 R5 R6: pattern rows
        for (int r = 0; r < ROWS; r++) begin
            int L, F, fails;
            pattern_en = 1'b0;
            set_line(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3]);
            vs_width = 10'(VEC[r][4]); v_back = 8'(VEC[r][5]);
            act_lines = 12'(VEC[r][6]); v_front = 8'(VEC[r][7]);
            de_inv = VEC[r][8][0]; hs_inv = VEC[r][9][0]; vs_inv = VEC[r][10][0];
            repeat (3) @(negedge clk);
            pattern_en = 1'b1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            L = VEC[r][0] + VEC[r][1] + VEC[r][2] + VEC[r][3];
            F = VEC[r][4] + VEC[r][5] + VEC[r][6] + VEC[r][7];
            fails = 0;
            for (int t = 0; t < L * F + 2 * L; t++) begin
                int pos, ln, x, b;
                bit ehs, evs, ede;
                logic [23:0] ergb;
                pos = t % L;
                ln  = (t / L) % F;
                ehs = pos < VEC[r][0];
                evs = ln < VEC[r][4];
                ede = (pos >= VEC[r][0] + VEC[r][1]) && (pos < VEC[r][0] + VEC[r][1] + VEC[r][2]) &&
                      (ln >= VEC[r][4] + VEC[r][5]) && (ln < VEC[r][4] + VEC[r][5] + VEC[r][6]);
                x = pos - VEC[r][0] - VEC[r][1];
                b = (x >> 4) & 7;
                ergb = ede ? {(b & 4) ? 8'hFF : 8'h00, (b & 2) ? 8'hFF : 8'h00,
                              (b & 1) ? 8'hFF : 8'h00} : 24'h0;
                chk(hs_o == (ehs ^ hs_inv), "R3 R2 R5 pattern hsync", hs_o, ehs ^ hs_inv);
                chk(vs_o == (evs ^ vs_inv), "R4 R2 R5 pattern vsync", vs_o, evs ^ vs_inv);
                chk(de_o == (ede ^ de_inv), "R4 R3 R2 pattern data-enable", de_o, ede ^ de_inv);
                chk(rgb_o == ergb, "R6 colour bars", rgb_o, ergb);
                @(negedge clk);
            end
        end

        // R10: leaving pattern mode blanks at once
        pattern_en = 1'b0;
        @(negedge clk);
        chk(de_o == de_inv && hs_o == hs_inv && vs_o == vs_inv, "R10 idle after pattern off",
            {de_o, hs_o, vs_o}, {de_inv, hs_inv, vs_inv});
        retime_cfg(40);
        repeat (4) @(negedge clk);

        // R7: delayed line launch and its shape
        launch(1'b0, 200, n);
        chk(n == 41, "R7 horizontal launch delay", n, 41);
        window(30, nhs, nde);
        chk(nhs == 3, "R7 sync width after launch", nhs, 3);
        chk(nde == 5, "R7 active clocks after launch", nde, 5);
        chk(hs_o == hs_inv && de_o == de_inv, "R7 idle after single line",
            {hs_o, de_o}, {hs_inv, de_inv});

        // R8: clamp boundaries
        sync_dly = 12'd5;  launch(1'b0, 200, n); chk(n == 33, "R8 clamp of 5", n, 33);  window(30, nhs, nde);
        sync_dly = 12'd0;  launch(1'b0, 200, n); chk(n == 33, "R8 clamp of 0", n, 33);  window(30, nhs, nde);
        sync_dly = 12'd32; launch(1'b0, 200, n); chk(n == 33, "R8 delay of 32", n, 33); window(30, nhs, nde);
        sync_dly = 12'd33; launch(1'b0, 200, n); chk(n == 34, "R8 delay of 33", n, 34); window(30, nhs, nde);

        // R11: second edge while pending restarts the count
        sync_dly = 12'd32;
        n = 0;
        hs_in = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 1)  hs_in = 1'b0;
            if (n == 10) hs_in = 1'b1;
            if (n == 11) hs_in = 1'b0;
            if (hs_o != hs_inv) break;
        end
        chk(n == 43, "R11 restart of pending delay", n, 43);
        window(30, nhs, nde);

        // R9: delayed vertical pulse, lines counted by line ends
        sync_dly = 12'd40;
        launch(1'b1, 200, n);
        chk(n == 41, "R9 vertical launch delay", n, 41);
        hs_in = 1'b1; @(negedge clk); hs_in = 1'b0;
        window(70, nhs, nde);
        chk(nde == 0, "R9 no data-enable in first vsync line", nde, 0);
        chk(vs_o != vs_inv, "R9 vsync held after one line", vs_o, !vs_inv);
        hs_in = 1'b1; @(negedge clk); hs_in = 1'b0;
        window(70, nhs, nde);
        chk(nde == 0, "R9 no data-enable in second vsync line", nde, 0);
        chk(vs_o == vs_inv, "R9 vsync released after two lines", vs_o, vs_inv);
        hs_in = 1'b1; @(negedge clk); hs_in = 1'b0;
        window(70, nhs, nde);
        chk(nde == 5, "R9 data-enable back after vsync", nde, 5);

        // R10: pending event dropped by a mode change
        hs_in = 1'b1; @(negedge clk); hs_in = 1'b0;
        repeat (3) @(negedge clk);
        pattern_en = 1'b1;
        repeat (4) @(negedge clk);
        pattern_en = 1'b0;
        @(negedge clk);
        window(120, nhs, nde);
        chk(nhs == 0, "R10 pending sync discarded", nhs, 0);
        chk(nde == 0, "R10 no data-enable after discard", nde, 0);

        finish_run();
    end

endmodule